// File: doc/BRIEF.md
# Emergency Pin High-Impedance Controller

This block watches an active-low emergency input and, when a request is detected, can float a group of output pins by asserting an output-enable override for each of them. A request is recognised in one of two ways. The first is a falling edge on the synchronized input. The second is a run of low samples taken at a divided clock, with three divisors to choose from. The request is held in a sticky flag in a single 16-bit control register. That register also holds a high-impedance enable bit, an interrupt enable bit and the 2-bit detection mode.

Software sees the register through a simple synchronous bus with select, write strobe, write data and read data. The flag cannot be set by software. It clears only through a fixed protocol: software reads the register while the flag is 1, then writes 0 to the flag bit. In the low-level modes the clear is also refused until the input has been seen high at the divided clock. The pin drivers, the pin multiplexing and the interrupt controller that consume `pinHiz` and `irq` sit outside this block.

Top module: `emerg_hiz_ctrl`

## Requirements
- R1: After reset the register reads 0x0000, every `pinHiz` bit is 0 and `irq` is 0.
- R2: With mode field bits [1:0] = 00, a falling edge on `emergInN` sets the flag (register bit 12) within four clock cycles. The input passes through a two-stage synchronizer first.
- R3: The low-level modes sample the synchronized input once every DIV1, DIV2 or DIV3 cycles, for mode codes 01, 10 and 11 respectively. The flag sets on the LOW_RUN-th consecutive low sample. A shorter run that ends in a high sample does not set it.
- R4: Writing 1 to bit 12 leaves the flag unchanged. A write of 0 to bit 12 clears the flag only if the register was read with the flag at 1 after the most recent set. Without such a read the write is ignored.
- R5: In a low-level mode, a clear write is also ignored unless a high sample has been taken at the divided clock since the flag was set.
- R6: When a set condition and a clear write fall in the same cycle, the flag stays 1. The earlier read no longer counts, so a following clear write is ignored until the register is read again.
- R7: Bit 9 is the high-impedance enable. All `pinHiz` bits are 1 when bit 9 and the flag are both 1, and all are 0 otherwise.
- R8: Bit 8 is the interrupt enable. `irq` is 1 exactly when bit 8 and the flag are both 1.
- R9: Bits 15:13 and 11:10 (and the unused bits 7:2) always read as 0 whatever is written to them. Bits 9, 8 and 1:0 read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous active-low reset |
| emergInN | input | 1 | Asynchronous active-low emergency request input |
| regSel | input | 1 | Register access strobe |
| regWr | input | 1 | 1 = write access, 0 = read access |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Current register contents |
| pinHiz | output | NUM_PINS | Per-pin output-enable override (1 = float the pin) |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DIV1=2, DIV2=4, DIV3=8 and LOW_RUN=3, and keeps NUM_PINS=8. These short divisors and the short run length let every low-level mode be taken through both a run that stops one sample short and a run that sets the flag, plus the refused and accepted clear sequences, in a few hundred cycles. The same-cycle collision between a set and a clear is timed exactly around the two synchronizer stages. Random configuration writes then check the readback masking and the `pinHiz`/`irq` gating against a bench model.

// File: rtl/emerg_hiz_pkg.sv
package emerg_hiz_pkg;
  localparam int FLAG_BIT = 12;
  localparam int HIZ_BIT  = 9;
  localparam int IEN_BIT  = 8;
  localparam logic [1:0] MODE_EDGE = 2'b00;

  typedef struct packed {
    logic setReq;    // selected detection condition met
    logic highTick;  // divided-clock sample saw the input high
    logic rdStb;     // register read access
    logic wrStb;     // register write access
  } strobes_t;
endpackage

// File: rtl/emerg_hiz_ctrl_unit.sv
module emerg_hiz_ctrl_unit
  import emerg_hiz_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV1 = 8,
  parameter int DIV2 = 16,
  parameter int DIV3 = 128,
  parameter int LOW_RUN = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       emergInN,
  input  logic       regSel,
  input  logic       regWr,
  input  logic [1:0] mode,
  output strobes_t   stb
);
  localparam int CNT_W = $clog2(DIV3 + 1);
  localparam int RUN_W = $clog2(LOW_RUN + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic syncIn, prevQ, tick, lvlEvt;
  logic [CNT_W-1:0] cntQ, divLast;
  logic [RUN_W-1:0] runQ;

  // synchronizer chain, stage 0 takes the raw pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= 1'b1;
    else       syncQ[0] <= emergInN;
  end
  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[g] <= 1'b1;
      else       syncQ[g] <= syncQ[g-1];
    end
  end
  assign syncIn = syncQ[SYNC_STAGES-1];

  always_comb begin
    case (mode)
      2'b10:   divLast = CNT_W'(DIV2 - 1);
      2'b11:   divLast = CNT_W'(DIV3 - 1);
      default: divLast = CNT_W'(DIV1 - 1);
    endcase
  end
  assign tick = (cntQ >= divLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ <= 1'b1;
      cntQ  <= '0;
      runQ  <= '0;
    end else begin
      prevQ <= syncIn;
      cntQ  <= tick ? '0 : cntQ + 1'b1;
      if (tick) begin
        if (syncIn)                        runQ <= '0;
        else if (runQ != RUN_W'(LOW_RUN))  runQ <= runQ + 1'b1;
      end
    end
  end

  assign lvlEvt = tick & ~syncIn & (runQ == RUN_W'(LOW_RUN - 1));

  assign stb.setReq   = (mode == MODE_EDGE) ? (prevQ & ~syncIn) : lvlEvt;
  assign stb.highTick = tick & syncIn;
  assign stb.rdStb    = regSel & ~regWr;
  assign stb.wrStb    = regSel & regWr;

  // R3
  lvl_needs_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setReq && mode != MODE_EDGE) |-> !syncIn);
  // R2
  edge_needs_high_before_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setReq && mode == MODE_EDGE) |-> ($past(syncIn) && !syncIn));
endmodule

// File: rtl/emerg_hiz_datapath.sv
module emerg_hiz_datapath
  import emerg_hiz_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            stb,
  input  logic [15:0]         wrData,
  output logic [1:0]          mode,
  output logic [15:0]         rdData,
  output logic [NUM_PINS-1:0] pinHiz,
  output logic                irq
);
  logic flagQ, hizEnQ, intEnQ, armedQ, highSeenQ;
  logic [1:0] modeQ;
  logic clrOk;
  logic unusedWr;

  assign unusedWr = ^{wrData[15:13], wrData[11:10], wrData[7:2]};

  assign clrOk = stb.wrStb & ~wrData[FLAG_BIT] & armedQ &
                 ((modeQ == MODE_EDGE) | highSeenQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0; hizEnQ <= 1'b0; intEnQ <= 1'b0;
      armedQ <= 1'b0; highSeenQ <= 1'b0; modeQ <= MODE_EDGE;
    end else begin
      if (stb.wrStb) begin
        hizEnQ <= wrData[HIZ_BIT];
        intEnQ <= wrData[IEN_BIT];
        modeQ  <= wrData[1:0];
      end
      flagQ <= stb.setReq | (flagQ & ~clrOk);
      if (stb.setReq || clrOk)        armedQ <= 1'b0;
      else if (stb.rdStb && flagQ)    armedQ <= 1'b1;
      if (stb.setReq)                 highSeenQ <= 1'b0;
      else if (stb.highTick)          highSeenQ <= 1'b1;
    end
  end

  always_comb begin
    rdData = '0;
    rdData[FLAG_BIT] = flagQ;
    rdData[HIZ_BIT]  = hizEnQ;
    rdData[IEN_BIT]  = intEnQ;
    rdData[1:0]      = modeQ;
  end

  assign mode   = modeQ;
  assign pinHiz = {NUM_PINS{flagQ & hizEnQ}};
  assign irq    = flagQ & intEnQ;

  // R2
  set_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.setReq |=> flagQ);
  // R4
  flag_rise_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> $past(stb.setReq));
  // R4
  clear_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagQ) |-> $past(armedQ && stb.wrStb && !wrData[FLAG_BIT]));
  // R5
  lvl_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(flagQ) && $past(modeQ) != MODE_EDGE) |-> $past(highSeenQ));
  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setReq && stb.wrStb) |=> (flagQ && !armedQ));
endmodule

// File: rtl/emerg_hiz_ctrl.sv
module emerg_hiz_ctrl
  import emerg_hiz_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DIV1 = 8,
  parameter int DIV2 = 16,
  parameter int DIV3 = 128,
  parameter int LOW_RUN = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                emergInN,
  input  logic                regSel,
  input  logic                regWr,
  input  logic [15:0]         regWdata,
  output logic [15:0]         regRdata,
  output logic [NUM_PINS-1:0] pinHiz,
  output logic                irq
);
  strobes_t   stb;
  logic [1:0] mode;

  emerg_hiz_ctrl_unit #(
    .SYNC_STAGES(2), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3), .LOW_RUN(LOW_RUN)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .emergInN(emergInN),
    .regSel(regSel), .regWr(regWr), .mode(mode), .stb(stb)
  );

  emerg_hiz_datapath #(.NUM_PINS(NUM_PINS)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(regWdata),
    .mode(mode), .rdData(regRdata), .pinHiz(pinHiz), .irq(irq)
  );
endmodule

// File: tb/test_emerg_hiz_ctrl.sv
module test_emerg_hiz_ctrl;
  localparam int NP = 8, D1 = 2, D2 = 4, D3 = 8, LR = 3;

  logic clk = 1'b0, rstN = 1'b0, emergInN = 1'b1;
  logic regSel = 1'b0, regWr = 1'b0;
  logic [15:0] regWdata = '0, regRdata;
  logic [NP-1:0] pinHiz;
  logic irq;
  int checks = 0, fails = 0;
  logic [15:0] rv;

  emerg_hiz_ctrl #(.NUM_PINS(NP), .DIV1(D1), .DIV2(D2), .DIV3(D3), .LOW_RUN(LR))
    i_emerg_hiz_ctrl (.clk(clk), .rstN(rstN), .emergInN(emergInN), .regSel(regSel),
      .regWr(regWr), .regWdata(regWdata), .regRdata(regRdata), .pinHiz(pinHiz), .irq(irq));

  always #2 clk = ~clk;

  function automatic logic [15:0] expWord(logic f, logic h, logic i, logic [1:0] m);
    return {3'b000, f, 2'b00, h, i, 6'b000000, m};
  endfunction
  function automatic logic [NP-1:0] expHiz(logic f, logic h);
    return (f & h) ? '1 : '0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic readReg(output logic [15:0] v);
    @(negedge clk); regSel = 1'b1; regWr = 1'b0; #1 v = regRdata;
    @(negedge clk); regSel = 1'b0;
  endtask
  task automatic writeReg(logic [15:0] d);
    @(negedge clk); regSel = 1'b1; regWr = 1'b1; regWdata = d;
    @(negedge clk); regSel = 1'b0; regWr = 1'b0;
  endtask
  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic levelTest(logic [1:0] m, int d);
    writeReg(expWord(1'b1, 1'b1, 1'b1, m));
    emergInN = 1'b1; waitCyc(2 * d + 4);
    emergInN = 1'b0; waitCyc((LR - 1) * d);
    emergInN = 1'b1; waitCyc(2 * d + 4);
    check("R3 short run", {16'h0, regRdata}, {16'h0, expWord(1'b0, 1'b1, 1'b1, m)});
    emergInN = 1'b0; waitCyc((LR + 1) * d + 4);
    check("R3 full run", {16'h0, regRdata}, {16'h0, expWord(1'b1, 1'b1, 1'b1, m)});
    check("R7 hiz on", {24'h0, pinHiz}, {24'h0, expHiz(1'b1, 1'b1)});
    check("R8 irq on", {31'h0, irq}, 32'h1);
    readReg(rv);
    writeReg(expWord(1'b0, 1'b1, 1'b1, m));
    check("R5 clear refused while low", {16'h0, regRdata}, {16'h0, expWord(1'b1, 1'b1, 1'b1, m)});
    emergInN = 1'b1; waitCyc(2 * d + 4);
    writeReg(expWord(1'b0, 1'b1, 1'b1, m));
    check("R5 clear after high", {16'h0, regRdata}, {16'h0, expWord(1'b0, 1'b1, 1'b1, m)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d, eWord;
    logic flagM;
    waitCyc(3); rstN = 1'b1; waitCyc(2);
    // R1
    readReg(rv);
    check("R1 reset reg", {16'h0, rv}, 32'h0);
    check("R1 reset pins", {24'h0, pinHiz}, 32'h0);
    check("R1 reset irq", {31'h0, irq}, 32'h0);
    // R9 and R4 (flag bit written 1 has no effect)
    writeReg(16'hFFFF);
    readReg(rv);
    check("R9 reserved zero", {16'h0, rv}, {16'h0, expWord(1'b0, 1'b1, 1'b1, 2'b11)});
    check("R4 write one no set", {31'h0, rv[12]}, 32'h0);
    check("R7 no flag no hiz", {24'h0, pinHiz}, 32'h0);
    // R2 edge detection with enables off
    writeReg(16'h1000);
    emergInN = 1'b0; waitCyc(4);
    check("R2 edge sets flag", {16'h0, regRdata}, {16'h0, expWord(1'b1, 1'b0, 1'b0, 2'b00)});
    check("R7 hiz disabled", {24'h0, pinHiz}, 32'h0);
    check("R8 irq disabled", {31'h0, irq}, 32'h0);
    writeReg(16'h0000);
    check("R4 clear without read", {16'h0, regRdata}, {16'h0, expWord(1'b1, 1'b0, 1'b0, 2'b00)});
    readReg(rv);
    writeReg(16'h1300);
    check("R4 write one keeps flag", {16'h0, regRdata}, {16'h0, expWord(1'b1, 1'b1, 1'b1, 2'b00)});
    check("R7 hiz enabled", {24'h0, pinHiz}, {24'h0, expHiz(1'b1, 1'b1)});
    check("R8 irq enabled", {31'h0, irq}, 32'h1);
    readReg(rv);
    writeReg(16'h0300);
    check("R4 read then clear", {16'h0, regRdata}, {16'h0, expWord(1'b0, 1'b1, 1'b1, 2'b00)});
    check("R8 irq dropped", {31'h0, irq}, 32'h0);
    emergInN = 1'b1; waitCyc(4);
    // R6 set and clear in the same cycle
    emergInN = 1'b0; waitCyc(4); emergInN = 1'b1; waitCyc(4);
    readReg(rv);
    @(negedge clk); emergInN = 1'b0;
    @(negedge clk);
    @(negedge clk); regSel = 1'b1; regWr = 1'b1; regWdata = 16'h0300;
    @(negedge clk); regSel = 1'b0; regWr = 1'b0;
    check("R6 set wins", {31'h0, irq}, 32'h1);
    writeReg(16'h0300);
    check("R6 read no longer counts", {31'h0, irq}, 32'h1);
    readReg(rv);
    writeReg(16'h0300);
    check("R6 clear after reread", {31'h0, irq}, 32'h0);
    emergInN = 1'b1; waitCyc(4);
    // R3 R5 low-level modes
    levelTest(2'b01, D1);
    levelTest(2'b10, D2);
    levelTest(2'b11, D3);
    // R9 R7 R8 random configuration writes, input idle high
    void'($urandom(32'h5eed1234));
    flagM = 1'b0;
    for (int k = 0; k < 40; k++) begin
      d = 16'($urandom()) | 16'h1000;
      writeReg(d);
      eWord = expWord(flagM, d[9], d[8], d[1:0]);
      check("R9 random readback", {16'h0, regRdata}, {16'h0, eWord});
      check("R7 random hiz", {24'h0, pinHiz}, {24'h0, expHiz(flagM, d[9])});
      check("R8 random irq", {31'h0, irq}, {31'h0, flagM & d[8]});
      if (k == 20) begin
        writeReg(16'h1300);
        emergInN = 1'b0; waitCyc(4); emergInN = 1'b1; waitCyc(4);
        flagM = 1'b1;
      end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule